// File: doc/BRIEF.md
# Slave Serial Audio Data Transmitter

This block takes stereo sample pairs from a converter-side parallel interface and shifts them out on one serial data line. It never makes its own clocks. An external master drives the bit clock and the word select, and the block launches each data bit on the active bit-clock edge, which an edge-select input picks. Both clocks are brought into the local system-clock domain through synchronizers. All framing decisions are made on the synchronized edges.

A three-bit mode input sets the format. Its top bit chooses right-aligned (LSB-justified) or I2S framing. The low two bits choose the word width and the number of bit clocks per frame. The converter side writes a pair into a holding register with a one-cycle valid strobe. The block moves the held pair into its shift register at the start of each left slot and pulses a request output, so the writer knows when to supply the next pair. An enable input releases the data line so that several transmitters can share one wire.

Top module: `serial_audio_tx`

## Requirements
- R1: The serial output changes only in response to an active bit-clock edge; while the bit clock is still, word-select activity leaves the output and the request line unchanged.
- R2: With `rise_sel_i` = 0 a new bit is launched after each falling bit-clock edge; with `rise_sel_i` = 1 it is launched after each rising edge. No bit is launched on two consecutive system-clock cycles.
- R3: `mode_i[2]` = 0 selects right-aligned framing and 1 selects I2S framing. `mode_i[1:0]` = 00 means 16-bit words in 16-bit slots (32 clocks per frame), 01 means 16-bit words in 32-bit slots, and 11 means 18-bit words in 32-bit slots.
- R4: The left sample of a pair is sent before the right sample. Word select high marks the left slot in right-aligned framing, and word select low marks it in I2S framing.
- R5: In right-aligned framing, the first bit of a slot is launched on the same edge as the word-select change. The word is sent MSB first, its LSB is the last bit of the slot, and any leading unused positions are 0.
- R6: In I2S framing, the MSB is launched one bit clock after the edge where word select changes. Positions after the LSB are 0, and the bit on the change edge is the last bit of the previous slot.
- R7: The 16-bit modes send sample bits 15:0, and the 18-bit mode sends bits 17:0.
- R8: `mode_i[1:0]` = 10 is not supported for transmission, and every bit sent in that mode is 0.
- R9: `sd_o` is driven only while `en_i` = 1. Otherwise the line is released to high impedance.
- R10: The held pair is loaded at the start of each left slot, and `smp_req_o` gives a one-cycle pulse for each load. A pair written after a load appears only in the next frame.
- R11: After reset an enabled output drives 0 and `smp_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Bit clock from the external master |
| ws_i | input | 1 | Word select from the external master |
| mode_i | input | 3 | Framing format, word width and slot length |
| rise_sel_i | input | 1 | Active bit-clock edge select (0 falling, 1 rising) |
| en_i | input | 1 | Output drive enable, active high |
| smp_l_i | input | 18 | Left sample to hold |
| smp_r_i | input | 18 | Right sample to hold |
| smp_vld_i | input | 1 | Strobe that writes the sample pair into the holding register |
| smp_req_o | output | 1 | Pulse when the held pair enters the shift register |
| sd_o | output | 1 | Serial data, high impedance when disabled |

## Verification
In every frame, a new pair is written while the previous pair is still being shifted out. This makes the writer's strobe and the transmitter's shifting act in the same frame. The bench checks that every bit of the frame in flight still comes from the older pair, and that the newer pair appears only after the next left-slot start. In I2S framing, the edge where word select changes also launches the last bit of the previous right slot. The load of the new frame follows on the next edge, so the bench checks that the boundary bit comes from the previous frame.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;
  localparam int SMP_W  = 18;
  localparam int SMP_AW = $clog2(SMP_W);
  localparam int FRM_W  = 64;
  localparam int FRM_AW = $clog2(FRM_W);
  localparam int SLOT_MAX = FRM_W / 2;

  typedef enum logic {FMT_RJ = 1'b0, FMT_I2S = 1'b1} fmt_e;

  // Builds the whole stereo frame, MSB-first, left slot in the upper half
  // of the active region; unused positions stay zero.
  function automatic logic [FRM_W-1:0] pack_frame(input logic [2:0]       mode,
                                                  input logic [SMP_W-1:0] lft,
                                                  input logic [SMP_W-1:0] rgt);
    logic [FRM_W-1:0] v;
    logic [SMP_W-1:0] s;
    int slot, wid, idx, pos;
    v    = '0;
    slot = mode[0] ? SLOT_MAX : SLOT_MAX / 2;
    wid  = (mode[1:0] == 2'b11) ? SMP_W : 16;
    if (mode[1:0] != 2'b10) begin
      for (int c = 0; c < 2; c++) begin
        for (int q = 0; q < SLOT_MAX; q++) begin
          if (q < slot) begin
            s   = (c == 0) ? lft : rgt;
            idx = mode[2] ? (wid - 1 - q) : (slot - 1 - q);
            if (idx >= 0 && idx < wid) begin
              pos = FRM_W - 1 - (c * slot + q);
              v[pos[FRM_AW-1:0]] = s[idx[SMP_AW-1:0]];
            end
          end
        end
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/sat_sync.sv
`timescale 1ns/1ps
module sat_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sat_edge.sv
`timescale 1ns/1ps
module sat_edge
  import sat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_i,
  input  logic ws_i,
  input  logic rise_sel_i,
  input  fmt_e fmt_i,
  output logic launch_o,
  output logic load_o
);
  logic bck_q, ws_q, pend_q;
  logic bck_d, ws_d, pend_d;
  logic rise, fall, left_lvl, left_start;

  always_comb begin
    rise       = bck_i & ~bck_q;
    fall       = ~bck_i & bck_q;
    launch_o   = rise_sel_i ? rise : fall;
    left_lvl   = (fmt_i == FMT_RJ);
    left_start = launch_o && (ws_i != ws_q) && (ws_i == left_lvl);
    load_o     = (fmt_i == FMT_I2S) ? (launch_o & pend_q) : left_start;
    bck_d      = bck_i;
    ws_d       = launch_o ? ws_i : ws_q;
    pend_d     = launch_o ? ((fmt_i == FMT_I2S) && left_start) : pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_q  <= 1'b0;
      ws_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      bck_q  <= bck_d;
      ws_q   <= ws_d;
      pend_q <= pend_d;
    end
  end

  // R2: launches are isolated single-cycle events
  p_launch_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);
  // R6: a pending I2S start is consumed by the very next launch
  p_pend_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && launch_o) |=> !pend_q);
endmodule

// File: rtl/sat_shift.sv
`timescale 1ns/1ps
module sat_shift
  import sat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             load_i,
  input  logic [FRM_W-1:0] frame_i,
  output logic             bit_o
);
  logic [FRM_W-1:0] sh_q, sh_d;
  logic             bit_q, bit_d;

  always_comb begin
    sh_d  = sh_q;
    bit_d = bit_q;
    if (launch_i) begin
      if (load_i) begin
        bit_d = frame_i[FRM_W-1];
        sh_d  = {frame_i[FRM_W-2:0], 1'b0};
      end else begin
        bit_d = sh_q[FRM_W-1];
        sh_d  = {sh_q[FRM_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
    end
  end

  assign bit_o = bit_q;

  // R10: the edge unit only asks for a load on a launch edge
  p_load_launch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> launch_i);
endmodule

// File: rtl/serial_audio_tx.sv
`timescale 1ns/1ps
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bck_i,
  input  logic             ws_i,
  input  logic [2:0]       mode_i,
  input  logic             rise_sel_i,
  input  logic             en_i,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  input  logic             smp_vld_i,
  output logic             smp_req_o,
  output wire              sd_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_n_s;
  logic [1:0]       clk_s;
  logic             launch, load, tx_bit;
  logic [SMP_W-1:0] hold_l_q, hold_r_q, hold_l_d, hold_r_d;
  logic             req_q, req_d;
  logic [FRM_W-1:0] frame_vec;
  fmt_e             fmt;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  sat_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .d_i   ({bck_i, ws_i}),
    .q_o   (clk_s)
  );

  assign fmt = mode_i[2] ? FMT_I2S : FMT_RJ;

  sat_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .bck_i     (clk_s[1]),
    .ws_i      (clk_s[0]),
    .rise_sel_i(rise_sel_i),
    .fmt_i     (fmt),
    .launch_o  (launch),
    .load_o    (load)
  );

  always_comb begin
    hold_l_d = smp_vld_i ? smp_l_i : hold_l_q;
    hold_r_d = smp_vld_i ? smp_r_i : hold_r_q;
    req_d    = load;
    frame_vec = pack_frame(mode_i, hold_l_q, hold_r_q);
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      req_q    <= 1'b0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      req_q    <= req_d;
    end
  end

  sat_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .launch_i(launch),
    .load_i  (load),
    .frame_i (frame_vec),
    .bit_o   (tx_bit)
  );

  assign smp_req_o = req_q;
  assign sd_o      = en_i ? tx_bit : 1'bz;

  // R10: one request pulse per load
  p_req_single_r10: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    smp_req_o |=> !smp_req_o);
  // R8: an unsupported code never loads a nonzero frame
  p_unsup_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (load && mode_i[1:0] == 2'b10) |-> (frame_vec == '0));
endmodule

// File: tb/serial_audio_tx_test.sv
`timescale 1ns/1ps
module serial_audio_tx_test;
  localparam int HALF = 8;

  // stimulus table: {mode[2:0], rise_sel, frames[3:0]}
  // R3 mode codes, R2 edge choice, R4 slot order, R7 word width are all
  // exercised by the bit-by-bit checks of these runs.
  localparam logic [7:0] VEC_TBL [6] = '{
    {3'b000, 1'b0, 4'd3},
    {3'b001, 1'b1, 4'd3},
    {3'b011, 1'b0, 4'd3},
    {3'b100, 1'b1, 4'd3},
    {3'b101, 1'b0, 4'd3},
    {3'b111, 1'b1, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bck = 1'b0, ws = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic        rise_sel = 1'b0, en = 1'b1;
  logic [17:0] smp_l = '0, smp_r = '0;
  logic        vld = 1'b0;
  logic        req;
  wire         sd_w;
  int          checks = 0, errors = 0, req_cnt = 0;

  pullup (sd_w);

  serial_audio_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .bck_i(bck), .ws_i(ws), .mode_i(mode),
    .rise_sel_i(rise_sel), .en_i(en), .smp_l_i(smp_l), .smp_r_i(smp_r),
    .smp_vld_i(vld), .smp_req_o(req), .sd_o(sd_w)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (req) req_cnt <= req_cnt + 1;

  function automatic logic [17:0] mk(input int f, input int base, input int ch);
    return 18'((base * 40503 + f * 77777 + ch * 12345) ^ 32'h2A6C9);
  endfunction

  // expected frame bit k (0 = first bit after left slot start)
  function automatic logic fb(input logic [2:0] m, input logic [17:0] l,
                              input logic [17:0] r, input int k);
    int s_len, w, c, q;
    logic [17:0] s;
    s_len = m[0] ? 32 : 16;
    w     = (m[1:0] == 2'b11) ? 18 : 16;
    if (m[1:0] == 2'b10) return 1'b0;
    c = (k >= s_len) ? 1 : 0;
    q = k - c * s_len;
    s = c ? r : l;
    if (!m[2]) return (q >= s_len - w) ? s[s_len - 1 - q] : 1'b0;
    return (q < w) ? s[w - 1 - q] : 1'b0;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_pair(input logic [17:0] l, input logic [17:0] r);
    @(negedge clk); smp_l = l; smp_r = r; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic bit_period(input logic wsv, input logic do_chk, input logic expv,
                            input string tag, input logic do_wr,
                            input logic [17:0] wl, input logic [17:0] wr);
    @(negedge clk); ws = wsv;
    @(negedge clk); bck = rise_sel;
    for (int i = 0; i < HALF - 1; i++) begin
      @(negedge clk);
      if (do_wr && i == 0) begin smp_l = wl; smp_r = wr; vld = 1'b1; end
      else vld = 1'b0;
    end
    if (do_chk) check(sd_w, expv, tag);
    bck = ~rise_sel;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] m, input logic es, input logic e);
    rst_n = 1'b0; mode = m; rise_sel = es; en = e; vld = 1'b0;
    bck = ~es; ws = m[2];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input logic [2:0] m, input logic es, input int nfr,
                     input logic e, input int base);
    int s_len, req0;
    logic left, prev, expv;
    string tag;
    do_reset(m, es, e);
    s_len = m[0] ? 32 : 16;
    left  = ~m[2];
    tag   = (m[1:0] == 2'b10) ? "R8" : (!e ? "R9" : (m[2] ? "R6" : "R5"));
    write_pair(mk(0, base, 0), mk(0, base, 1));
    req0 = req_cnt;
    for (int i = 0; i < 4; i++) bit_period(~left, 1'b0, 1'b0, tag, 1'b0, '0, '0);
    prev = 1'b0;
    for (int f = 0; f < nfr; f++) begin
      // R10: pair f+1 is written while frame f is still shifting out
      for (int k = 0; k < 2 * s_len; k++) begin
        if (!e) expv = 1'b1;
        else if (m[2]) expv = (k == 0) ? prev : fb(m, mk(f, base, 0), mk(f, base, 1), k - 1);
        else expv = fb(m, mk(f, base, 0), mk(f, base, 1), k);
        bit_period((k < s_len) ? left : ~left, 1'b1, expv, tag, k == 4,
                   mk(f + 1, base, 0), mk(f + 1, base, 1));
      end
      prev = fb(m, mk(f, base, 0), mk(f, base, 1), 2 * s_len - 1);
    end
    checks++;
    if (req_cnt - req0 != nfr) begin
      errors++;
      $display("FAIL R10: %0d request pulses expected %0d", req_cnt - req0, nfr);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic held;
    int   rq;
    // R11: reset state with the output enabled
    do_reset(3'b001, 1'b0, 1'b1);
    check(sd_w, 1'b0, "R11");
    check(req, 1'b0, "R11");

    for (int v = 0; v < 6; v++)
      run(VEC_TBL[v][7:5], VEC_TBL[v][4], int'(VEC_TBL[v][3:0]), 1'b1, v + 1);

    // R1: bit clock held still, word select toggling: nothing moves
    held = sd_w; rq = req_cnt;
    for (int i = 0; i < 6; i++) begin
      repeat (5) @(negedge clk); ws = ~ws;
    end
    repeat (6) @(negedge clk);
    check(sd_w, held, "R1");
    checks++;
    if (req_cnt != rq) begin
      errors++;
      $display("FAIL R1: request count %0d expected %0d", req_cnt, rq);
    end

    // R8: unsupported code sends only zeros
    run(3'b010, 1'b1, 2, 1'b1, 9);
    run(3'b110, 1'b0, 1, 1'b1, 10);
    // R9: disabled output is released (pull-up reads 1)
    run(3'b001, 1'b0, 1, 1'b0, 11);
    // R2 with the opposite edge on an 18-bit right-aligned frame
    run(3'b011, 1'b1, 1, 1'b1, 12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule